// File: doc/BRIEF.md
# Integer add/subtract flag unit

This block is the fixed-point add/subtract stage of an integer execution pipe. A 4-bit operation code selects one of twelve add, subtract or negate forms. The forms share one `W`-bit adder. Its first input is either `ra` or `~ra`. Its second input is `rb`, a sign-extended immediate, all ones, or zero. Its carry-in is 0, 1 or the stored carry flag. The sum appears on `result` in the same cycle, with no register in the path.

The unit keeps three flag bits in registers: carry (`ca`), overflow (`ov`) and a sticky summary overflow (`so`). When `issue` is high, the flags are written on the next rising clock edge. Carry is written by every carrying form, whatever the state of `oe`. Overflow is written only when `oe` is high, and a 1 written to overflow also sets the summary bit. Only reset or `flag_clr` clears the summary bit. Condition recording, multiply and divide belong to other blocks.

Top module: `int_arith_flags`

## Requirements
- R1: After reset, `ca`, `ov` and `so` are all 0.
- R2: The add forms produce `result` in the same cycle. Code 0 is plain add and code 1 is carrying add; both give ra+B. Code 2 is extended add and gives ra+B+ca. Code 3 gives ra+(-1)+ca and code 4 gives ra+0+ca. Here B is `rb`, or the immediate `imm` sign-extended to W bits when `use_imm`=1.
- R3: The subtract forms produce `result` in the same cycle. Code 5 is plain subtract and code 6 is carrying subtract; both give ~ra+B+1. Code 7 gives ~ra+B+ca. Code 8 gives ~ra+(-1)+ca and code 9 gives ~ra+0+ca. Code 10 always uses the sign-extended immediate and gives ~ra+imm+1.
- R4: Code 11 (negate) gives ~ra+1. When `oe`=1, its overflow is 1 exactly when ra is the most negative value (only the top bit set).
- R5: On an issued code 1, 2, 3 or 4, `ca` takes the carry out of bit W-1 of the add. For code 1 this is "result < ra" (unsigned). For codes 2 to 4 it is "result < ra, or incoming ca=1 and result == ra".
- R6: On an issued code 6, 7, 8, 9 or 10, `ca` takes the carry out of ~ra+B+cin. For codes 6 and 10 this is "result <= B" (unsigned). For codes 7 to 9 it is "result < B, or incoming ca=1 and result == B".
- R7: `ca` keeps its value for codes 0, 5 and 11. Codes 12 to 15 are unused: `result` is 0 and no flag changes. With `issue`=0, no flag changes whatever the inputs.
- R8: With `oe`=1, an issued code writes `ov`. For add forms, `ov` is 1 when both adder inputs have the same sign and the result sign differs from the first input. Subtract forms use the same test with ~ra as the first input. With `oe`=0, `ov` and `so` keep their values.
- R9: `so` becomes 1 whenever `ov` is written as 1. Writing 0 to `ov` leaves `so` unchanged.
- R10: `flag_clr`=1 clears `ca`, `ov` and `so` on the next edge, and takes priority over `issue`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_clr | input | 1 | Synchronous clear of all flags |
| issue | input | 1 | Operation valid; flags update at the next edge |
| op | input | 4 | Operation code (see R2 to R4) |
| oe | input | 1 | Overflow enable: allows `ov` and `so` to be written |
| use_imm | input | 1 | Second operand is the sign-extended `imm` instead of `rb` |
| ra | input | W (32) | First operand |
| rb | input | W (32) | Second register operand |
| imm | input | IW (16) | Signed immediate |
| result | output | W (32) | Sum or difference, combinational |
| ca | output | 1 | Carry flag |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary overflow |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. They cover the stability of the flags when nothing is issued, the gating of `ov` and `so` by the enable, and the stickiness of `so`. They also cover the priority of the clear, the carrying-add carry compare and the negate result. Other behaviour is shown only by the directed scenarios. These cover the equality branch of the extended carry rules, the constant second operand of the minus-one and zero forms, and the most-negative negate overflow. They also cover the forced immediate of code 10 and the unused codes. The scenarios compare each case with a wide-arithmetic model kept in the bench.

// File: rtl/iaf_pkg.sv
package iaf_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_ADDE   = 4'd2,
        OP_ADDME  = 4'd3,
        OP_ADDZE  = 4'd4,
        OP_SUBF   = 4'd5,
        OP_SUBFC  = 4'd6,
        OP_SUBFE  = 4'd7,
        OP_SUBFME = 4'd8,
        OP_SUBFZE = 4'd9,
        OP_SUBFI  = 4'd10,
        OP_NEG    = 4'd11
    } arith_op_e;

    typedef enum logic [1:0] {
        BSRC_OPND = 2'd0,
        BSRC_ONES = 2'd1,
        BSRC_ZERO = 2'd2
    } bsrc_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CARRY = 2'd2
    } cin_e;

    typedef enum logic [2:0] {
        CAR_NONE    = 3'd0,
        CAR_ADD_LT  = 3'd1,
        CAR_ADD_EXT = 3'd2,
        CAR_SUB_LE  = 3'd3,
        CAR_SUB_EXT = 3'd4
    } carry_rule_e;

    typedef struct packed {
        logic        known;
        logic        invert_a;
        logic        force_imm;
        logic        is_neg;
        bsrc_e       bsrc;
        cin_e        cin;
        carry_rule_e rule;
    } arith_ctrl_t;

endpackage

// File: rtl/iaf_decode.sv
module iaf_decode
    import iaf_pkg::*;
(
    input  logic [3:0]  op,
    output arith_ctrl_t ctrl
);
    always_comb begin
        ctrl = '{known: 1'b1, invert_a: 1'b0, force_imm: 1'b0, is_neg: 1'b0,
                 bsrc: BSRC_OPND, cin: CIN_ZERO, rule: CAR_NONE};
        unique case (arith_op_e'(op))
            OP_ADD:    ;
            OP_ADDC:   ctrl.rule = CAR_ADD_LT;
            OP_ADDE:   begin ctrl.cin = CIN_CARRY; ctrl.rule = CAR_ADD_EXT; end
            OP_ADDME:  begin ctrl.cin = CIN_CARRY; ctrl.rule = CAR_ADD_EXT;
                             ctrl.bsrc = BSRC_ONES; end
            OP_ADDZE:  begin ctrl.cin = CIN_CARRY; ctrl.rule = CAR_ADD_EXT;
                             ctrl.bsrc = BSRC_ZERO; end
            OP_SUBF:   begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_ONE; end
            OP_SUBFC:  begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_ONE;
                             ctrl.rule = CAR_SUB_LE; end
            OP_SUBFE:  begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_CARRY;
                             ctrl.rule = CAR_SUB_EXT; end
            OP_SUBFME: begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_CARRY;
                             ctrl.rule = CAR_SUB_EXT; ctrl.bsrc = BSRC_ONES; end
            OP_SUBFZE: begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_CARRY;
                             ctrl.rule = CAR_SUB_EXT; ctrl.bsrc = BSRC_ZERO; end
            OP_SUBFI:  begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_ONE;
                             ctrl.rule = CAR_SUB_LE; ctrl.force_imm = 1'b1; end
            OP_NEG:    begin ctrl.invert_a = 1'b1; ctrl.cin = CIN_ONE;
                             ctrl.bsrc = BSRC_ZERO; ctrl.is_neg = 1'b1; end
            default:   ctrl.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/iaf_datapath.sv
module iaf_datapath
    import iaf_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 16
) (
    input  arith_ctrl_t   ctrl,
    input  logic          use_imm,
    input  logic          ca_q,
    input  logic [W-1:0]  ra,
    input  logic [W-1:0]  rb,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  opx,
    output logic [W-1:0]  opy,
    output logic [W-1:0]  sum,
    output logic          ov_raw
);
    localparam int unsigned EXT = W - IW;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] imm_ext;
    logic         cin;

    assign imm_ext = {{EXT{imm[IW-1]}}, imm};

    always_comb begin
        opx = ctrl.invert_a ? ~ra : ra;
        unique case (ctrl.bsrc)
            BSRC_ONES: opy = '1;
            BSRC_ZERO: opy = '0;
            default:   opy = (use_imm || ctrl.force_imm) ? imm_ext : rb;
        endcase
        unique case (ctrl.cin)
            CIN_ONE:   cin = 1'b1;
            CIN_CARRY: cin = ca_q;
            default:   cin = 1'b0;
        endcase
    end

    assign sum = opx + opy + {{(W-1){1'b0}}, cin};

    always_comb begin
        if (ctrl.is_neg)
            ov_raw = (ra == MOST_NEG);
        else
            ov_raw = ~(opx[W-1] ^ opy[W-1]) & (opx[W-1] ^ sum[W-1]);
    end
endmodule

// File: rtl/iaf_carry.sv
module iaf_carry
    import iaf_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  carry_rule_e  rule,
    input  logic         ca_q,
    input  logic [W-1:0] opx,
    input  logic [W-1:0] opy,
    input  logic [W-1:0] sum,
    output logic         ca_we,
    output logic         ca_nx
);
    always_comb begin
        ca_we = 1'b1;
        unique case (rule)
            CAR_ADD_LT:  ca_nx = (sum < opx);
            CAR_ADD_EXT: ca_nx = (sum < opx) || (ca_q && (sum == opx));
            CAR_SUB_LE:  ca_nx = (sum <= opy);
            CAR_SUB_EXT: ca_nx = (sum < opy) || (ca_q && (sum == opy));
            default: begin
                ca_we = 1'b0;
                ca_nx = ca_q;
            end
        endcase
    end
endmodule

// File: rtl/int_arith_flags.sv
module int_arith_flags
    import iaf_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag_clr,
    input  logic          issue,
    input  logic [3:0]    op,
    input  logic          oe,
    input  logic          use_imm,
    input  logic [W-1:0]  ra,
    input  logic [W-1:0]  rb,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  result,
    output logic          ca,
    output logic          ov,
    output logic          so
);
    arith_ctrl_t  ctrl;
    logic [W-1:0] opx, opy, sum;
    logic         ov_raw, ca_we, ca_nx;

    iaf_decode u_dec (.op(op), .ctrl(ctrl));

    iaf_datapath #(.W(W), .IW(IW)) u_dp (
        .ctrl(ctrl), .use_imm(use_imm), .ca_q(ca), .ra(ra), .rb(rb), .imm(imm),
        .opx(opx), .opy(opy), .sum(sum), .ov_raw(ov_raw)
    );

    iaf_carry #(.W(W)) u_car (
        .rule(ctrl.rule), .ca_q(ca), .opx(opx), .opy(opy), .sum(sum),
        .ca_we(ca_we), .ca_nx(ca_nx)
    );

    assign result = ctrl.known ? sum : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca <= 1'b0;
            ov <= 1'b0;
            so <= 1'b0;
        end else if (flag_clr) begin
            ca <= 1'b0;
            ov <= 1'b0;
            so <= 1'b0;
        end else if (issue && ctrl.known) begin
            if (ca_we) ca <= ca_nx;
            if (oe) begin
                ov <= ov_raw;
                if (ov_raw) so <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iaf_checker.sv
module iaf_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flag_clr,
    input logic         issue,
    input logic [3:0]   op,
    input logic         oe,
    input logic [W-1:0] ra,
    input logic [W-1:0] result,
    input logic         ca,
    input logic         ov,
    input logic         so
);
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!ca && !ov && !so));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !flag_clr) |=> $stable({ca, ov, so}));

    a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !oe && !flag_clr) |=> $stable({ov, so}));

    a_r9_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (so && !flag_clr) |=> so);

    a_r9_so_follows_ov: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov) |-> so);

    a_r5_addc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd1 && !flag_clr) |=> (ca == ($past(result) < $past(ra))));

    a_r4_neg_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd11) |-> ((result + ra) == '0));
endmodule

bind int_arith_flags iaf_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .issue(issue), .op(op),
    .oe(oe), .ra(ra), .result(result), .ca(ca), .ov(ov), .so(so)
);

// File: tb/int_arith_flags_tb.sv
module int_arith_flags_tb;
    localparam int W  = 32;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag_clr = 1'b0;
    logic          issue = 1'b0;
    logic [3:0]    op = 4'd0;
    logic          oe = 1'b0;
    logic          use_imm = 1'b0;
    logic [W-1:0]  ra = '0;
    logic [W-1:0]  rb = '0;
    logic [IW-1:0] imm = '0;
    logic [W-1:0]  result;
    logic          ca, ov, so;

    int n_vec = 0;
    int n_bad = 0;
    logic m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;

    always #10 clk = ~clk;

    int_arith_flags #(.W(W), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .issue(issue), .op(op),
        .oe(oe), .use_imm(use_imm), .ra(ra), .rb(rb), .imm(imm),
        .result(result), .ca(ca), .ov(ov), .so(so)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " ca"}, {31'd0, ca}, {31'd0, m_ca});
        chk({req, " ov"}, {31'd0, ov}, {31'd0, m_ov});
        chk({req, " so"}, {31'd0, so}, {31'd0, m_so});
    endtask

    // Drive one issued operation, check the result mid-cycle and the flags after the edge.
    task automatic run_op(input int code, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [IW-1:0] im, input logic ui, input logic o,
                          input string req);
        logic [W-1:0] x, y, e_res;
        logic [W:0]   wsum;
        logic         cin, wr_ca, known, e_ov;
        logic signed [W:0] ssum;
        logic [W-1:0] bsel;
        bsel = (ui || code == 10) ? {{(W-IW){im[IW-1]}}, im} : b;
        known = 1'b1; wr_ca = 1'b0; x = a; y = bsel; cin = 1'b0;
        case (code)
            0:  ;
            1:  wr_ca = 1'b1;
            2:  begin cin = m_ca; wr_ca = 1'b1; end
            3:  begin cin = m_ca; wr_ca = 1'b1; y = '1; end
            4:  begin cin = m_ca; wr_ca = 1'b1; y = '0; end
            5:  begin x = ~a; cin = 1'b1; end
            6:  begin x = ~a; cin = 1'b1; wr_ca = 1'b1; end
            7:  begin x = ~a; cin = m_ca; wr_ca = 1'b1; end
            8:  begin x = ~a; cin = m_ca; wr_ca = 1'b1; y = '1; end
            9:  begin x = ~a; cin = m_ca; wr_ca = 1'b1; y = '0; end
            10: begin x = ~a; cin = 1'b1; wr_ca = 1'b1; end
            11: begin x = ~a; cin = 1'b1; y = '0; end
            default: known = 1'b0;
        endcase
        wsum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        ssum  = $signed({x[W-1], x}) + $signed({y[W-1], y}) + $signed({{W{1'b0}}, cin});
        e_ov  = (ssum[W] != ssum[W-1]);
        e_res = known ? wsum[W-1:0] : '0;
        @(negedge clk);
        op = code[3:0]; ra = a; rb = b; imm = im; use_imm = ui; oe = o; issue = 1'b1;
        #3;
        chk({req, " result"}, result, e_res);
        @(negedge clk);
        issue = 1'b0;
        if (known) begin
            if (wr_ca) m_ca = wsum[W];
            if (o) begin
                m_ov = e_ov;
                if (e_ov) m_so = 1'b1;
            end
        end
        chk_flags(req);
    endtask

    task automatic do_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_ca = 1'b0; m_ov = 1'b0; m_so = 1'b0;
    endtask

    task automatic t_reset();
        #3;
        chk_flags("R1 reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R1 after release");
    endtask

    task automatic t_add_forms();
        run_op(1, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, "R5 addc wrap");
        run_op(0, 32'h5, 32'h0, 16'hFFFD, 1'b1, 1'b0, "R2 add imm, R7 ca kept");
        run_op(1, 32'h1, 32'h2, 16'h0, 1'b0, 1'b0, "R5 addc no carry");
        run_op(1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, "R8 addc overflow");
        run_op(0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R8 add neg overflow");
    endtask

    task automatic t_add_ext();
        do_clear();
        run_op(1, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, "R5 set ca");
        run_op(2, 32'h5, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, "R5 adde equal with ca");
        run_op(2, 32'h10, 32'h20, 16'h0, 1'b0, 1'b0, "R2 adde carry in");
        run_op(3, 32'h0, 32'h1234, 16'h0, 1'b0, 1'b1, "R2 addme ca0");
        run_op(3, 32'h8000_0000, 32'h0, 16'h0, 1'b0, 1'b1, "R8 addme overflow");
        run_op(4, 32'hFFFF_FFFF, 32'h55, 16'h0, 1'b0, 1'b0, "R2 addze");
        run_op(4, 32'hFFFF_FFFF, 32'h55, 16'h0, 1'b0, 1'b0, "R5 addze with ca");
    endtask

    task automatic t_sub_forms();
        do_clear();
        run_op(6, 32'h0, 32'h7, 16'h0, 1'b0, 1'b0, "R6 subfc a=0 equal");
        run_op(6, 32'h8, 32'h7, 16'h0, 1'b0, 1'b0, "R6 subfc borrow");
        run_op(10, 32'h3, 32'hDEAD, 16'h0003, 1'b0, 1'b0, "R3 subfi forced imm");
        run_op(10, 32'h1, 32'h0, 16'h8000, 1'b0, 1'b1, "R6 subfi negative imm");
        run_op(5, 32'h1, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R3 subf overflow, R7 ca kept");
        run_op(6, 32'h5, 32'h0, 16'h0009, 1'b1, 1'b0, "R3 subfc imm select");
    endtask

    task automatic t_sub_ext();
        do_clear();
        run_op(7, 32'h3, 32'h9, 16'h0, 1'b0, 1'b0, "R6 subfe ca0");
        run_op(6, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, "R6 set ca");
        run_op(7, 32'h0, 32'h9, 16'h0, 1'b0, 1'b0, "R6 subfe equal with ca");
        run_op(8, 32'h0, 32'h0, 16'h0, 1'b0, 1'b1, "R3 subfme");
        run_op(8, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0, 1'b0, "R6 subfme");
        run_op(9, 32'h0, 32'h77, 16'h0, 1'b0, 1'b0, "R3 subfze");
        run_op(9, 32'h8000_0000, 32'h0, 16'h0, 1'b0, 1'b1, "R6 subfze");
    endtask

    task automatic t_neg();
        do_clear();
        run_op(11, 32'h5, 32'h0, 16'h0, 1'b0, 1'b1, "R4 neg small");
        run_op(11, 32'h8000_0000, 32'h0, 16'h0, 1'b0, 1'b1, "R4 neg most negative");
        run_op(11, 32'h0, 32'h0, 16'h0, 1'b0, 1'b1, "R4 neg zero, R9 so kept");
    endtask

    task automatic t_oe_gate();
        do_clear();
        run_op(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0, "R8 overflow masked");
        run_op(11, 32'h8000_0000, 32'h0, 16'h0, 1'b0, 1'b0, "R8 neg masked");
    endtask

    task automatic t_sticky();
        do_clear();
        run_op(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, "R9 ov set");
        run_op(0, 32'h1, 32'h1, 16'h0, 1'b0, 1'b1, "R9 ov cleared so stays");
        chk("R9 so sticky", {31'd0, so}, 32'd1);
    endtask

    task automatic t_clear();
        run_op(1, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, "R10 prime ca");
        @(negedge clk);
        flag_clr = 1'b1; issue = 1'b1; op = 4'd0; oe = 1'b1;
        ra = 32'h7FFF_FFFF; rb = 32'h1; use_imm = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0; issue = 1'b0;
        m_ca = 1'b0; m_ov = 1'b0; m_so = 1'b0;
        chk_flags("R10 clear over issue");
    endtask

    task automatic t_idle_unused();
        run_op(1, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, "R7 prime ca");
        @(negedge clk);
        issue = 1'b0; op = 4'd1; ra = 32'h1; rb = 32'h1; oe = 1'b1;
        @(negedge clk);
        chk_flags("R7 idle hold");
        run_op(13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b1, "R7 unused code");
        run_op(15, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, "R7 unused code 15");
    endtask

    initial begin
        t_reset();
        t_add_forms();
        t_add_ext();
        t_sub_forms();
        t_sub_ext();
        t_neg();
        t_oe_gate();
        t_sticky();
        t_clear();
        t_idle_unused();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule